// File: doc/BRIEF.md
# Next-Line Prefetch Controller

This block sits beside a cache and decides when to ask the memory side for the line that follows the one just referenced. It watches the stream of demand accesses (line address plus hit or miss), hears about completed fills, and produces at most one outstanding prefetch request, carrying the address of the next sequential line, over a valid/ready handshake.

Three trigger policies can be selected at run time. In the first, every reference requests the next line. In the second, only misses do. In the third, a per-line marker bit records whether a line brought in by prefetch has been used yet, and the first use of such a line requests its successor. A fourth setting turns prefetching off. A waiting request is overwritten by a newer one rather than queued, and a request for the line most recently handed over is dropped.

Top module: `nlpf_ctrl`

## Requirements
- R1: With mode code 0 (every reference), each access (acc_valid high) whose target is not a duplicate (R6) raises pf_valid on the next cycle, whether the access hits or misses.
- R2: With mode code 1 (miss only), an access with acc_hit low raises a non-duplicate request on the next cycle; an access with acc_hit high raises none.
- R3: With mode code 2 (marker mode), a fill with fill_pf high clears the marker of the line whose low IDX_W address bits match; the first hit to that line then raises a request and sets the marker, and a further hit raises none.
- R4: With mode code 2, an access with acc_hit low raises a request; a fill with fill_pf low sets the marker, so a later hit to that line raises no request.
- R5: The requested address pf_line equals the accessed line address plus one, modulo 2^ADDR_W (the highest line requests line 0).
- R6: A trigger whose target equals the most recently accepted request (pf_valid and pf_ready high at one edge, including that same edge) is dropped.
- R7: While pf_valid is high and pf_ready low, pf_valid and pf_line hold unless a new non-duplicate trigger arrives, which replaces pf_line with the newer target.
- R8: mode_sel is taken into the active mode only at an edge where pf_valid is low; while a request is pending the previous mode stays in force.
- R9: With mode code 3 (off), no access raises a request.
- R10: After reset, pf_valid is low, the active mode is off, and every marker is set, so a hit in marker mode to a line never filled by prefetch raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Policy: 0 every reference, 1 miss only, 2 marker, 3 off |
| acc_valid | input | 1 | A demand access happens this cycle |
| acc_line | input | ADDR_W | Line address of the access |
| acc_hit | input | 1 | The access hit in the cache |
| fill_valid | input | 1 | A line fill completes this cycle |
| fill_line | input | ADDR_W | Line address of the completed fill |
| fill_pf | input | 1 | The fill was for a prefetch (high) or a demand miss (low) |
| pf_ready | input | 1 | Memory side accepts the pending request |
| pf_valid | output | 1 | A prefetch request is pending |
| pf_line | output | ADDR_W | Line address to prefetch |

## Verification
The assertions assume that acc_line, acc_hit and acc_valid are meaningful on every cycle in which acc_valid is high, and that the memory side may hold pf_ready low for any number of cycles. The stimulus drives at most one access per cycle, changes all inputs on the falling edge, and only requests a mode change while no request is pending so the moment the new mode takes effect is known. Fills are issued on cycles without an access, which keeps the marker update order unambiguous for the bench's own model of the markers.

// File: rtl/nlpf_pkg.sv
// Shared types for the next-line prefetch controller.
// Assumes: the mode code is two bits wide and decoded by value.
package nlpf_pkg;

    typedef enum logic [1:0] {
        PFM_EVERY  = 2'd0,
        PFM_MISS   = 2'd1,
        PFM_MARKER = 2'd2,
        PFM_OFF    = 2'd3
    } pf_mode_e;

endpackage

// File: rtl/nlpf_mode_reg.sv
// Active-policy register.
// Takes the requested policy only when the load enable is high (no request
// pending), so a request in flight is always governed by one policy.
// Assumes: mode_sel is a plain two-bit code; reset selects the off policy.
module nlpf_mode_reg
    import nlpf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_en,
    input  logic [1:0] mode_sel,
    output pf_mode_e active_mode
);

    // Hold or reload the active policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_mode <= PFM_OFF;
        end else if (load_en) begin
            active_mode <= pf_mode_e'(mode_sel);
        end
    end

endmodule

// File: rtl/nlpf_tag_bits.sv
// Per-line "used since prefetch" marker bits.
// One bit per index; cleared by a prefetch fill, set by a demand fill or
// any hit. A hit in the same cycle as a fill to the same index wins.
// Assumes: the index is the low IDX_W bits of the line address.
module nlpf_tag_bits #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_pf,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] mark_q;

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        // Update the marker of one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q[gi] <= 1'b1;
            end else if (ref_en && (ref_idx == IDX_W'(gi))) begin
                mark_q[gi] <= 1'b1;
            end else if (fill_en && (fill_idx == IDX_W'(gi))) begin
                mark_q[gi] <= ~fill_pf;
            end
        end
    end

    // Read the marker of the line being accessed.
    always_comb begin
        rd_bit = mark_q[rd_idx];
    end

endmodule

// File: rtl/nlpf_trigger.sv
// Trigger decision for one access under the active policy.
// Assumes: tag_bit is the marker of the accessed line before this access.
module nlpf_trigger
    import nlpf_pkg::*;
(
    input  pf_mode_e mode,
    input  logic     acc_valid,
    input  logic     acc_hit,
    input  logic     tag_bit,
    output logic     fire
);

    // Decide whether this access wants its successor line.
    always_comb begin
        fire = 1'b0;
        if (acc_valid) begin
            unique case (mode)
                PFM_EVERY:  fire = 1'b1;
                PFM_MISS:   fire = ~acc_hit;
                PFM_MARKER: fire = ~acc_hit | ~tag_bit;
                PFM_OFF:    fire = 1'b0;
                default:    fire = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/nlpf_req_reg.sv
// Single-entry request register with duplicate suppression.
// A new trigger overwrites a pending request; a trigger for the line most
// recently handed over (including one handed over at this very edge) is
// dropped.
// Assumes: pf_ready may stay low indefinitely.
module nlpf_req_reg #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] target,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_line
);

    logic              last_v;
    logic [ADDR_W-1:0] last_line;
    logic              take;
    logic              recent_v;
    logic [ADDR_W-1:0] recent_line;
    logic              load;

    // Find the most recently accepted line, counting this edge's handover.
    always_comb begin
        take        = pf_valid & pf_ready;
        recent_v    = take | last_v;
        recent_line = take ? pf_line : last_line;
        load        = fire & ~(recent_v & (target == recent_line));
    end

    // Load, hold or retire the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_line  <= '0;
        end else if (load) begin
            pf_valid <= 1'b1;
            pf_line  <= target;
        end else if (take) begin
            pf_valid <= 1'b0;
        end
    end

    // Remember the last line the memory side accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_v    <= 1'b0;
            last_line <= '0;
        end else if (take) begin
            last_v    <= 1'b1;
            last_line <= pf_line;
        end
    end

endmodule

// File: rtl/nlpf_ctrl.sv
// Next-line prefetch controller, top level.
// Ties the policy register, marker bits, trigger decision and request
// register together. The requested line is the accessed line plus one,
// wrapping at ADDR_W bits.
// Assumes: IDX_W <= ADDR_W; one access and one fill per cycle at most.
module nlpf_ctrl
    import nlpf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_line,
    input  logic              acc_hit,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_line,
    input  logic              fill_pf,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_line
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    pf_mode_e          active_mode;
    logic              tag_bit;
    logic              fire;
    logic [ADDR_W-1:0] next_line;

    // Successor line address, wrapping at the top of the address space.
    always_comb begin
        next_line = acc_line + STEP;
    end

    nlpf_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (~pf_valid),
        .mode_sel    (mode_sel),
        .active_mode (active_mode)
    );

    nlpf_tag_bits #(.IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (acc_valid & acc_hit),
        .ref_idx  (acc_line[IDX_W-1:0]),
        .fill_en  (fill_valid),
        .fill_idx (fill_line[IDX_W-1:0]),
        .fill_pf  (fill_pf),
        .rd_idx   (acc_line[IDX_W-1:0]),
        .rd_bit   (tag_bit)
    );

    nlpf_trigger u_trig (
        .mode      (active_mode),
        .acc_valid (acc_valid),
        .acc_hit   (acc_hit),
        .tag_bit   (tag_bit),
        .fire      (fire)
    );

    nlpf_req_reg #(.ADDR_W(ADDR_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .target   (next_line),
        .pf_ready (pf_ready),
        .pf_valid (pf_valid),
        .pf_line  (pf_line)
    );

endmodule

// File: rtl/nlpf_ctrl_chk.sv
// Property checker for the next-line prefetch controller, bound to the top.
// Assumes: inputs change away from the rising edge.
module nlpf_ctrl_chk
    import nlpf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_line,
    input logic              acc_hit,
    input logic              pf_ready,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_line,
    input pf_mode_e          active_mode
);

    logic [ADDR_W-1:0] succ_line;
    always_comb succ_line = acc_line + ADDR_W'(1);

    AST_RISE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(acc_valid)); // R1

    AST_RISE_IS_SUCCESSOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> (pf_line == $past(succ_line))); // R5

    AST_HIT_QUIET_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == PFM_MISS && acc_valid && acc_hit && !pf_valid) |=> !pf_valid); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !acc_valid) |=> (pf_valid && $stable(pf_line))); // R7

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> $stable(active_mode)); // R8

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == PFM_OFF && !pf_valid) |=> !pf_valid); // R9

endmodule

bind nlpf_ctrl nlpf_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_line    (acc_line),
    .acc_hit     (acc_hit),
    .pf_ready    (pf_ready),
    .pf_valid    (pf_valid),
    .pf_line     (pf_line),
    .active_mode (active_mode)
);

// File: tb/nlpf_ctrl_test.sv
`timescale 1ns/1ps
module nlpf_ctrl_test;

    localparam int AW = 5;
    localparam int IW = 3;
    localparam int NL = 1 << AW;
    localparam int NI = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'd3;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_line = '0;
    logic          acc_hit = 1'b0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_line = '0;
    logic          fill_pf = 1'b0;
    logic          pf_ready = 1'b1;
    logic          pf_valid;
    logic [AW-1:0] pf_line;

    int total = 0;
    int bad = 0;

    // bench model
    bit     mtag [NI];
    int     mmode = 3;
    bit     mlast_v = 1'b0;
    int     mlast = 0;

    always #2 clk = ~clk;

    nlpf_ctrl #(.ADDR_W(AW), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .acc_valid(acc_valid), .acc_line(acc_line), .acc_hit(acc_hit),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_pf(fill_pf),
        .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one access cycle; entered and left at a falling edge
    task automatic drive_acc(input int line, input bit hit);
        acc_valid = 1'b1;
        acc_line  = AW'(line);
        acc_hit   = hit;
        @(negedge clk);
        acc_valid = 1'b0;
        if (hit) mtag[line % NI] = 1'b1;
    endtask

    task automatic step(input int line, input bit hit, input string req);
        bit fire;
        int tgt;
        bit expv;
        case (mmode)
            0: fire = 1'b1;
            1: fire = !hit;
            2: fire = !hit || !mtag[line % NI];
            default: fire = 1'b0;
        endcase
        tgt  = (line + 1) % NL;
        expv = fire && !(mlast_v && tgt == mlast);
        drive_acc(line, hit);
        chk(req, pf_valid, expv);
        if (expv) begin
            chk(req, pf_line, tgt);
            mlast_v = 1'b1;
            mlast   = tgt;
        end
        @(negedge clk);
        chk(req, pf_valid, 0);
    endtask

    task automatic do_fill(input int line, input bit is_pf);
        fill_valid = 1'b1;
        fill_line  = AW'(line);
        fill_pf    = is_pf;
        @(negedge clk);
        fill_valid = 1'b0;
        mtag[line % NI] = !is_pf;
    endtask

    task automatic set_mode(input int m);
        mode_sel = 2'(m);
        repeat (2) @(negedge clk);
        mmode = m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NI; i++) mtag[i] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", pf_valid, 0);
        @(negedge clk);
        chk("R10", pf_valid, 0);

        // R10: markers start set, so a marker-mode hit stays quiet
        set_mode(2);
        for (int i = 0; i < NL; i++) step(i, 1'b1, "R10");

        // R1 / R5: every reference, full sweep including the wrap
        set_mode(0);
        for (int i = 0; i < NL; i++) step(i, i[0], (i == NL - 1) ? "R5" : "R1");

        // R6: repeated reference to one line, then a fresh one
        step(7, 1'b1, "R6");
        step(7, 1'b1, "R6");
        step(7, 1'b0, "R6");
        step(8, 1'b1, "R6");

        // R2: miss-only policy across all lines
        set_mode(1);
        for (int i = 0; i < NL; i++) step(i, (i % 3) != 0, "R2");

        // R3: prefetch fill clears, first hit fires, second hit quiet
        set_mode(2);
        for (int i = 0; i < NI; i++) begin
            do_fill(i, 1'b1);
            step(i, 1'b1, "R3");
            step(i, 1'b1, "R3");
        end

        // R4: demand miss fires, demand fill sets the marker
        for (int i = 0; i < NI; i++) begin
            step(i + NI, 1'b0, "R4");
            do_fill(i + NI, 1'b0);
            step(i + NI, 1'b1, "R4");
        end

        // R7 / R8: stalled request replaced, mode frozen while pending
        set_mode(0);
        pf_ready = 1'b0;
        drive_acc(3, 1'b1);
        chk("R7", pf_valid, 1);
        chk("R7", pf_line, 4);
        drive_acc(10, 1'b1);
        chk("R7", pf_line, 11);
        mode_sel = 2'd3;
        repeat (2) @(negedge clk);
        chk("R7", pf_valid, 1);
        chk("R7", pf_line, 11);
        drive_acc(20, 1'b0);
        chk("R8", pf_valid, 1);
        chk("R8", pf_line, 21);
        pf_ready = 1'b1;
        @(negedge clk);
        chk("R8", pf_valid, 0);
        mlast_v = 1'b1;
        mlast   = 21;
        @(negedge clk);
        mmode = 3;

        // R9: off policy issues nothing
        for (int i = 0; i < NL; i++) step(i, i[1], "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule